// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency pulse train by counting its rising edges over a gate window of known length. A control bit `start` arms it. While `start` is 0 the count is cleared. A 0-to-1 change of `start` begins a measurement. The measurement has two parts: a settling wait, whose length follows from the gate choice, and then the gate window. Pulses are counted only while the gate is open. When the gate closes, `done` rises. The count stays on `count` for as long as `start` stays 1, so that a controller can shift it out MSB first.

The frequency follows from the count divided by the gate time. For example, 342400 edges in a 32 ms gate is 10.7 MHz. A millisecond time base is taken from the system clock through the parameter `CLK_PER_MS`. The IF input may be asynchronous: it passes through a synchronizer and an edge detector before it reaches the counter. While `inhibit` is high the whole measurement is frozen.

Top module: `if_freq_counter`

## Requirements
- R1: After reset, `count` is 0 and `done` is 0.
- R2: The gate select is decoded as follows: 00 gives a 4 ms gate after a 4 ms wait, 01 gives 8 ms after a 4 ms wait, 10 gives 32 ms after an 8 ms wait, and 11 gives 64 ms after an 8 ms wait. Let E0 be the clock edge that first samples `start` = 1. Then `done` becomes 1 on the edge (wait+gate)·`CLK_PER_MS` clock edges after E0, and it is 0 before that edge.
- R3: Exactly one count is added for each rising edge of `if_pulse` that is detected while the gate is open. Edges that arrive during the wait, or after `done`, are not counted. For a periodic input whose period divides the gate length, the result is the gate length in cycles divided by the period.
- R4: When `start` is sampled as 0, `count` and `done` are 0 after the next clock edge.
- R5: `gate_sel` is captured on the 0-to-1 change of `start`. Changes to it later in the measurement do not alter the timing.
- R6: While `inhibit` is 1, no edges are counted and the wait and gate timers are paused. `count` and `done` hold their values, and the measurement resumes when `inhibit` returns to 0.
- R7: The count saturates at its all-ones value (2^COUNT_W − 1) and does not wrap.
- R8: If `start` drops to 0 and rises again during a measurement, the old measurement is abandoned and a full new wait and gate begin from the new rise.
- R9: While `start` stays 1 after `done`, `done` stays 1 and `count` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_pulse | input | 1 | IF pulse input, possibly asynchronous |
| start | input | 1 | 0 clears the block; a 0-to-1 change starts a measurement |
| gate_sel | input | 2 | Gate-time select, captured at start |
| inhibit | input | 1 | 1 freezes the measurement |
| count | output | COUNT_W | Edge count of the current or last gate |
| done | output | 1 | 1 once the gate window has closed |

## Verification
Several properties are checked on every cycle:
- a low `start` clears the outputs;
- an inhibited cycle leaves `count` and `done` unchanged;
- a finished result holds;
- the saturated count stays put;
- the millisecond counter never passes its limit;
- two detected edges never come back to back.

Other behaviours can only be shown by the bench's scenarios. These are the exact edge on which `done` rises for each gate choice, the exact count for periodic inputs, the capture of `gate_sel` at start, the restart after a short drop of `start`, and the pause of the timers under `inhibit`.

// File: rtl/ifc_pkg.sv
`timescale 1ns/1ps
package ifc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_GATE = 2'd2,
    ST_DONE = 2'd3
  } ifc_state_e;

  localparam int unsigned MS_W = 7;

  // gate window length in milliseconds
  function automatic int unsigned gate_ms(input logic [1:0] sel);
    case (sel)
      2'b00:   gate_ms = 4;
      2'b01:   gate_ms = 8;
      2'b10:   gate_ms = 32;
      default: gate_ms = 64;
    endcase
  endfunction

  // settling wait before the gate opens, in milliseconds
  function automatic int unsigned wait_ms(input logic [1:0] sel);
    wait_ms = sel[1] ? 8 : 4;
  endfunction

endpackage

// File: rtl/ifc_edge.sv
`timescale 1ns/1ps
module ifc_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q[0] <= din;
      for (int i = 1; i < int'(SYNC_STAGES); i++) begin
        sync_q[i] <= sync_q[i-1];
      end
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~last_q;

  // R3: a detected edge is a single-cycle event
  assert_single_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/ifc_timer.sv
`timescale 1ns/1ps
module ifc_timer #(
  parameter int unsigned CLK_PER_MS = 50000,
  parameter int unsigned MS_W       = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            run,
  input  logic [MS_W-1:0] limit,
  output logic            expire
);

  localparam int unsigned TICK_W = $clog2(CLK_PER_MS + 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(CLK_PER_MS - 1);

  logic [TICK_W-1:0] tick_cnt;
  logic [MS_W-1:0]   ms_cnt;
  logic              tick;

  assign tick   = run && (tick_cnt == TICK_LAST);
  assign expire = tick && (ms_cnt == limit - MS_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      ms_cnt   <= '0;
    end else if (clear) begin
      tick_cnt <= '0;
      ms_cnt   <= '0;
    end else if (run) begin
      if (tick) begin
        tick_cnt <= '0;
        ms_cnt   <= expire ? '0 : ms_cnt + MS_W'(1);
      end else begin
        tick_cnt <= tick_cnt + TICK_W'(1);
      end
    end
  end

  // R2: elapsed milliseconds never reach the active window length
  assert_ms_below_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ms_cnt < limit));

endmodule

// File: rtl/ifc_accum.sv
`timescale 1ns/1ps
module ifc_accum #(
  parameter int unsigned COUNT_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               inc,
  output logic [COUNT_W-1:0] count
);

  localparam logic [COUNT_W-1:0] FULL = {COUNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (inc && (count != FULL)) begin
      count <= count + COUNT_W'(1);
    end
  end

  // R4: clearing empties the counter on the next edge
  assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));

  // R3: without a counted edge the value does not move
  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !inc) |=> $stable(count));

  // R7: full scale is sticky
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && count == FULL) |=> (count == FULL));

endmodule

// File: rtl/if_freq_counter.sv
`timescale 1ns/1ps
module if_freq_counter #(
  parameter int unsigned CLK_PER_MS  = 50000,
  parameter int unsigned COUNT_W     = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               if_pulse,
  input  logic               start,
  input  logic [1:0]         gate_sel,
  input  logic               inhibit,
  output logic [COUNT_W-1:0] count,
  output logic               done
);
  import ifc_pkg::*;

  localparam int unsigned LIM_W = ifc_pkg::MS_W;

  ifc_state_e state;
  logic       start_q;
  logic [1:0] sel_q;
  logic       start_rise;
  logic       timing;
  logic       gate_open;
  logic       timer_clear;
  logic       timer_run;
  logic       expire;
  logic       edge_seen;
  logic [LIM_W-1:0] limit;

  assign start_rise  = start & ~start_q;
  assign timing      = (state == ST_WAIT) || (state == ST_GATE);
  assign gate_open   = (state == ST_GATE) && !inhibit;
  assign timer_clear = start_rise | ~start;
  assign timer_run   = timing && !inhibit && start && !start_rise;
  assign limit       = (state == ST_WAIT) ? LIM_W'(wait_ms(sel_q))
                                          : LIM_W'(gate_ms(sel_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      sel_q   <= 2'b00;
      state   <= ST_IDLE;
    end else begin
      start_q <= start;
      if (!start) begin
        state <= ST_IDLE;
      end else if (start_rise) begin
        state <= ST_WAIT;
        sel_q <= gate_sel;
      end else if (!inhibit) begin
        case (state)
          ST_WAIT: if (expire) state <= ST_GATE;
          ST_GATE: if (expire) state <= ST_DONE;
          default: state <= state;
        endcase
      end
    end
  end

  assign done = (state == ST_DONE);

  ifc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (if_pulse),
    .rise  (edge_seen)
  );

  ifc_timer #(.CLK_PER_MS(CLK_PER_MS), .MS_W(LIM_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (timer_clear),
    .run    (timer_run),
    .limit  (limit),
    .expire (expire)
  );

  ifc_accum #(.COUNT_W(COUNT_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (timer_clear),
    .inc   (gate_open & edge_seen),
    .count (count)
  );

  // R4: a low start empties the result and drops done
  assert_stop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (count == '0 && !done));

  // R6: an inhibited cycle inside a measurement changes nothing visible
  assert_inhibit_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && start && start_q) |=> ($stable(count) && $stable(done)));

  // R9: a finished result is held while start stays high
  assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (done && $stable(count)));

  // R5: captured gate choice cannot move mid-measurement
  assert_sel_captured_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_q) |=> $stable(sel_q));

endmodule

// File: tb/if_freq_counter_test.sv
`timescale 1ns/1ps
module if_freq_counter_test;

  localparam int unsigned CPM = 10;

  typedef struct packed {
    logic [1:0]  sel;
    logic [7:0]  per;
    logic [15:0] expect_cnt;
  } vec_t;

  // gate cycles = gate_ms * CPM; expected count = gate cycles / period
  localparam vec_t VEC [6] = '{
    '{2'd0, 8'd2,  16'd20},
    '{2'd1, 8'd4,  16'd20},
    '{2'd2, 8'd5,  16'd64},
    '{2'd3, 8'd10, 16'd64},
    '{2'd3, 8'd2,  16'd320},
    '{2'd0, 8'd10, 16'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        if_pulse = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  gate_sel = 2'b00;
  logic        inhibit = 1'b0;
  logic [19:0] count;
  logic        done;
  logic [3:0]  count_sat;
  logic        done_sat;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  int pulse_per = 2;
  int phase = 0;

  always #10 clk = ~clk;

  // free-running pulse source: one high cycle every pulse_per cycles
  always @(negedge clk) begin
    phase    <= (phase + 1 >= pulse_per) ? 0 : phase + 1;
    if_pulse <= (phase == 0);
  end

  if_freq_counter #(.CLK_PER_MS(CPM), .COUNT_W(20)) uut (
    .clk(clk), .rst_n(rst_n), .if_pulse(if_pulse), .start(start),
    .gate_sel(gate_sel), .inhibit(inhibit), .count(count), .done(done)
  );

  if_freq_counter #(.CLK_PER_MS(CPM), .COUNT_W(4)) uut_sat (
    .clk(clk), .rst_n(rst_n), .if_pulse(if_pulse), .start(start),
    .gate_sel(gate_sel), .inhibit(inhibit), .count(count_sat), .done(done_sat)
  );

  function automatic int total_cycles(input logic [1:0] s);
    int g;
    int w;
    w = (s >= 2) ? 8 : 4;
    g = 4 << ((s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 3 : 4);
    return (w + g) * CPM;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic arm(input logic [1:0] s, input int per);
    @(negedge clk);
    start     = 1'b0;
    gate_sel  = s;
    pulse_per = per;
    repeat (3) @(negedge clk);
    start = 1'b1;
  endtask

  task automatic run_vector(input vec_t v, input bit with_sat);
    int k;
    k = total_cycles(v.sel);
    arm(v.sel, int'(v.per));
    repeat (k) @(posedge clk);
    #1 check("R2 done before window end", int'(done), 0);
    @(posedge clk);
    #1 check("R2 done at window end", int'(done), 1);
    check("R3 gated count", int'(count), int'(v.expect_cnt));
    if (with_sat) check("R7 saturated count", int'(count_sat), 15);
    repeat (5) @(posedge clk);
    #1 check("R9 result held", int'(count), int'(v.expect_cnt));
    check("R9 done held", int'(done), 1);
    @(negedge clk) start = 1'b0;
    @(posedge clk);
    #1 check("R4 count cleared", int'(count), 0);
    check("R4 done cleared", int'(done), 0);
  endtask

  initial begin
    int k;
    repeat (4) @(negedge clk);
    #1 check("R1 reset count", int'(count), 0);
    check("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle count", int'(count), 0);

    for (int i = 0; i < 6; i++) run_vector(VEC[i], i == 0);

    // R5: select change after start is ignored
    k = total_cycles(2'd0);
    arm(2'd0, 4);
    repeat (5) @(posedge clk);
    @(negedge clk) gate_sel = 2'd3;
    repeat (k - 5) @(posedge clk);
    #1 check("R5 done not early", int'(done), 0);
    @(posedge clk);
    #1 check("R5 done on captured gate", int'(done), 1);
    check("R5 count on captured gate", int'(count), 10);

    // R6: inhibit pauses counting and timing for 10 edges
    arm(2'd0, 2);
    repeat (51) @(posedge clk);
    @(negedge clk) inhibit = 1'b1;
    check("R6 count before inhibit", int'(count), 5);
    repeat (10) @(posedge clk);
    #1 check("R6 count frozen", int'(count), 5);
    @(negedge clk) inhibit = 1'b0;
    repeat (29) @(posedge clk);
    #1 check("R6 done delayed", int'(done), 0);
    @(posedge clk);
    #1 check("R6 done after pause", int'(done), 1);
    check("R6 count excludes inhibited edges", int'(count), 20);

    // R8: short drop of start restarts the measurement
    k = total_cycles(2'd1);
    arm(2'd1, 2);
    repeat (60) @(posedge clk);
    @(negedge clk) start = 1'b0;
    @(posedge clk);
    #1 check("R8 drop clears", int'(count), 0);
    @(negedge clk) start = 1'b1;
    repeat (k) @(posedge clk);
    #1 check("R8 restarted window", int'(done), 0);
    @(posedge clk);
    #1 check("R8 done after full restart", int'(done), 1);
    check("R8 count after restart", int'(count), 40);

    @(negedge clk) start = 1'b0;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule